// File: doc/BRIEF.md
# BCD Calendar Clock Core

This block keeps wall-clock time and calendar date entirely in BCD: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A prescaler counts pulses of a reference enable (one pulse per oscillator period, brought into the system clock domain upstream) and emits one second tick after a parameterised number of pulses. A select input picks one of two divisors, so either of two common watch-crystal frequencies can drive it. Carries ripple from seconds up through the year. February lengths follow a divisible-by-four rule across the two-digit year range.

A host reaches every field through a small register port with one address per field and a control word. A host write to any time or date field stores the value and restarts the sub-second count, so the next second is a full second. The control word selects 12-hour or 24-hour hour format. It also carries a write-only command that rounds the time to the nearest minute. Read back, the command bit position reports whether the control word has been written since reset.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hour 0x12 (12-hour mode, AM), weekday 0x00, day 0x01, month 0x01, year 0x00, and the control word reads 0x02.
- R2: With `ref_sel` = 0 seconds advance once every DIV_A `ref_tick` pulses, and with `ref_sel` = 1 once every DIV_B pulses, counted from the last restart of the prescaler.
- R3: Seconds and minutes count in BCD from 0x00 to 0x59. Seconds wrap to 0x00 with a carry into minutes, and minutes wrap to 0x00 with a carry into the hour.
- R4: With control bit 0 = 1 (24-hour), hours count 0x00..0x23, and the 0x23 to 0x00 step advances the date.
- R5: With control bit 0 = 0 (12-hour), the hour field holds a BCD hour 1..12 in bits 4:0 and a PM flag in bit 5. Hours go 12, 01 .. 11 per half-day. The flag toggles on the 11 to 12 step, and the date advances on the PM 11 (0x31) to AM 12 (0x12) step.
- R6: The weekday counts 0..6, wraps from 6 to 0, and advances together with the day of month.
- R7: The day of month wraps to 0x01 after the month's last day (31 for months 01/03/05/07/08/10/12, 30 for 04/06/09/11). The month wraps from 0x12 to 0x01 with a carry into the year, and the year wraps from 0x99 to 0x00.
- R8: February has 29 days when the BCD year taken as a number is a multiple of 4 (including 00) and 28 days otherwise.
- R9: A write to address 0..6 (0 seconds, 1 minutes, 2 hour, 3 weekday, 4 day, 5 month, 6 year) reads back at once and restarts the prescaler.
- R10: Writing control bit 1 = 1 while seconds are 0x00..0x29 sets seconds to 0x00, restarts the prescaler and leaves the minutes unchanged.
- R11: Writing control bit 1 = 1 while seconds are 0x30..0x59 sets seconds to 0x00, restarts the prescaler and advances the minutes by one, with the normal carry through hours and date.
- R12: Address 7 reads bit 0 = hour format and bit 1 = a flag that is 1 from reset until the first control write. Bits 7:2 read 0, and the round command never reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle pulse per reference oscillator period |
| ref_sel | input | 1 | Divisor select: 0 uses DIV_A, 1 uses DIV_B |
| wr_en | input | 1 | Host write strobe |
| addr | input | 3 | Field address (0..6 time/date, 7 control) |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Read data of the addressed field, combinational |

## Verification
The bench builds the core with DIV_A = 4 and DIV_B = 5 instead of the crystal-sized defaults. A simulated second then costs only a handful of cycles. This brings minute sweeps, hour, day, month and year rollovers, both leap cases and the two divisors within a short run. The two divisors differ by one, so a wrong selection shows up as an early or late second.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int unsigned FIELD_W = 8;

  // control word bit positions
  localparam int unsigned CTL_MODE24 = 0;
  localparam int unsigned CTL_ROUND  = 1;

  // field addresses
  localparam logic [2:0] A_SEC  = 3'd0;
  localparam logic [2:0] A_MIN  = 3'd1;
  localparam logic [2:0] A_HOUR = 3'd2;
  localparam logic [2:0] A_WDAY = 3'd3;
  localparam logic [2:0] A_MDAY = 3'd4;
  localparam logic [2:0] A_MON  = 3'd5;
  localparam logic [2:0] A_YEAR = 3'd6;
  localparam logic [2:0] A_CTL  = 3'd7;

  typedef struct packed {
    logic       wrap;
    logic [7:0] val;
  } step_t;

  // BCD increment with wrap from last to first
  function automatic step_t bcd_step(input logic [7:0] v,
                                     input logic [7:0] last,
                                     input logic [7:0] first);
    step_t r;
    if (v == last) begin
      r.wrap = 1'b1;
      r.val  = first;
    end else if (v[3:0] == 4'h9) begin
      r.wrap = 1'b0;
      r.val  = {v[7:4] + 4'h1, 4'h0};
    end else begin
      r.wrap = 1'b0;
      r.val  = v + 8'h01;
    end
    return r;
  endfunction

  // leap test: tens*10 + ones mod 4 == (tens*2 + ones) mod 4
  function automatic logic is_leap(input logic [7:0] yr);
    logic [4:0] s;
    s = {yr[7:4], 1'b0} + {1'b0, yr[3:0]};
    return (s[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon,
                                            input logic [7:0] yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // hour advance; wrap flags a new day
  function automatic step_t hour_step(input logic [7:0] h, input logic mode24);
    step_t r;
    if (mode24) begin
      r = bcd_step(h, 8'h23, 8'h00);
    end else begin
      r.wrap = 1'b0;
      if (h[4:0] == 5'h11) begin
        r.val  = {2'b00, ~h[5], 5'h12};
        r.wrap = h[5];
      end else if (h[4:0] == 5'h12) begin
        r.val = {2'b00, h[5], 5'h01};
      end else begin
        r.val = {2'b00, h[5], 5'h00} | {3'b000, bcd_step({3'b000, h[4:0]}, 8'h12, 8'h01).val[4:0]};
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned DIV_A = 32768,
  parameter int unsigned DIV_B = 32000,
  localparam int unsigned DMAX = (DIV_A > DIV_B) ? DIV_A : DIV_B,
  localparam int unsigned PW   = $clog2(DMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_tick,
  input  logic          ref_sel,
  input  logic          clr,
  output logic          sec_tick,
  output logic [PW-1:0] count
);

  logic [PW-1:0] last;

  assign last     = ref_sel ? PW'(DIV_B - 1) : PW'(DIV_A - 1);
  assign sec_tick = ref_tick && !clr && (count >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (clr)      count <= '0;
    else if (sec_tick) count <= '0;
    else if (ref_tick) count <= count + 1'b1;
  end

endmodule

// File: rtl/rtc_clock_chain.sv
module rtc_clock_chain
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       round_cmd,
  input  logic       mode24,
  input  logic       wr_sec,
  input  logic       wr_min,
  input  logic       wr_hour,
  input  logic [7:0] wr_data,
  output logic [7:0] sec,
  output logic [7:0] min,
  output logic [7:0] hour,
  output logic       min_step,
  output logic       hour_adv,
  output logic       day_carry
);

  step_t sec_nx, min_nx, hour_nx;

  assign sec_nx   = bcd_step(sec, 8'h59, 8'h00);
  assign min_nx   = bcd_step(min, 8'h59, 8'h00);
  assign hour_nx  = hour_step(hour, mode24);

  assign min_step  = (sec_tick && sec_nx.wrap) || (round_cmd && (sec >= 8'h30));
  assign hour_adv  = min_step && min_nx.wrap;
  assign day_carry = hour_adv && hour_nx.wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sec <= 8'h00;
    else if (wr_sec)    sec <= wr_data & 8'h7F;
    else if (round_cmd) sec <= 8'h00;
    else if (sec_tick)  sec <= sec_nx.val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        min <= 8'h00;
    else if (wr_min)   min <= wr_data & 8'h7F;
    else if (min_step) min <= min_nx.val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hour <= 8'h12;
    else if (wr_hour)  hour <= wr_data & 8'h3F;
    else if (hour_adv) hour <= hour_nx.val;
  end

endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       day_carry,
  input  logic       wr_wday,
  input  logic       wr_mday,
  input  logic       wr_mon,
  input  logic       wr_year,
  input  logic [7:0] wr_data,
  output logic [7:0] wday,
  output logic [7:0] mday,
  output logic [7:0] mon,
  output logic [7:0] year,
  output logic       mon_carry,
  output logic       year_carry
);

  step_t wday_nx, mday_nx, mon_nx, year_nx;

  assign wday_nx = bcd_step(wday, 8'h06, 8'h00);
  assign mday_nx = bcd_step(mday, month_last(mon, year), 8'h01);
  assign mon_nx  = bcd_step(mon, 8'h12, 8'h01);
  assign year_nx = bcd_step(year, 8'h99, 8'h00);

  assign mon_carry  = day_carry && mday_nx.wrap;
  assign year_carry = mon_carry && mon_nx.wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         wday <= 8'h00;
    else if (wr_wday)   wday <= wr_data & 8'h07;
    else if (day_carry) wday <= wday_nx.val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mday <= 8'h01;
    else if (wr_mday)   mday <= wr_data & 8'h3F;
    else if (day_carry) mday <= mday_nx.val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mon <= 8'h01;
    else if (wr_mon)    mon <= wr_data & 8'h1F;
    else if (mon_carry) mon <= mon_nx.val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          year <= 8'h00;
    else if (wr_year)    year <= wr_data;
    else if (year_carry) year <= year_nx.val;
  end

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter int unsigned DIV_A = 32768,
  parameter int unsigned DIV_B = 32000,
  localparam int unsigned DMAX  = (DIV_A > DIV_B) ? DIV_A : DIV_B,
  localparam int unsigned PW    = $clog2(DMAX + 1),
  localparam int unsigned NADDR = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       ref_sel,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data
);

  logic [NADDR-1:0] wr_sel;
  logic             round_cmd, presc_clr, sec_tick;
  logic [PW-1:0]    presc_cnt;
  logic             mode24, unset_flag;
  logic [7:0]       sec, min, hour, wday, mday, mon, year;
  logic             min_step, hour_adv, day_carry, mon_carry, year_carry;

  for (genvar g = 0; g < NADDR; g++) begin : g_wsel
    assign wr_sel[g] = wr_en && (addr == 3'(g));
  end

  assign round_cmd = wr_sel[A_CTL] && wr_data[CTL_ROUND];
  assign presc_clr = (|wr_sel[A_YEAR:A_SEC]) || round_cmd;

  rtc_prescaler #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .ref_sel  (ref_sel),
    .clr      (presc_clr),
    .sec_tick (sec_tick),
    .count    (presc_cnt)
  );

  rtc_clock_chain u_clock (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_tick  (sec_tick),
    .round_cmd (round_cmd),
    .mode24    (mode24),
    .wr_sec    (wr_sel[A_SEC]),
    .wr_min    (wr_sel[A_MIN]),
    .wr_hour   (wr_sel[A_HOUR]),
    .wr_data   (wr_data),
    .sec       (sec),
    .min       (min),
    .hour      (hour),
    .min_step  (min_step),
    .hour_adv  (hour_adv),
    .day_carry (day_carry)
  );

  rtc_date_chain u_date (
    .clk        (clk),
    .rst_n      (rst_n),
    .day_carry  (day_carry),
    .wr_wday    (wr_sel[A_WDAY]),
    .wr_mday    (wr_sel[A_MDAY]),
    .wr_mon     (wr_sel[A_MON]),
    .wr_year    (wr_sel[A_YEAR]),
    .wr_data    (wr_data),
    .wday       (wday),
    .mday       (mday),
    .mon        (mon),
    .year       (year),
    .mon_carry  (mon_carry),
    .year_carry (year_carry)
  );

  // control word: hour format and the since-reset flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode24     <= 1'b0;
      unset_flag <= 1'b1;
    end else if (wr_sel[A_CTL]) begin
      mode24     <= wr_data[CTL_MODE24];
      unset_flag <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      A_SEC:   rd_data = sec;
      A_MIN:   rd_data = min;
      A_HOUR:  rd_data = hour;
      A_WDAY:  rd_data = wday;
      A_MDAY:  rd_data = mday;
      A_MON:   rd_data = mon;
      A_YEAR:  rd_data = year;
      default: rd_data = {6'b0, unset_flag, mode24};
    endcase
  end

endmodule

// File: rtl/rtc_calendar_checker.sv
module rtc_calendar_checker #(
  parameter int unsigned PW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sec_tick,
  input logic          round_cmd,
  input logic [7:0]    wr_sel,
  input logic          mode24,
  input logic [PW-1:0] presc_cnt,
  input logic          min_step,
  input logic          day_carry,
  input logic [7:0]    sec,
  input logic [7:0]    min,
  input logic [7:0]    hour,
  input logic [7:0]    wday
);

  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);

  a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && sec == 8'h59) |=> (sec == 8'h00 && min != $past(min)));

  a_r4_day_at_midnight: assert property (@(posedge clk) disable iff (!rst_n)
    (min_step && mode24 && min == 8'h59 && hour == 8'h23) |-> day_carry);

  a_r5_ampm_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (min_step && !mode24 && min == 8'h59 && hour[4:0] == 5'h11 && !wr_sel[2])
      |=> (hour[5] != $past(hour[5])));

  a_r6_wday_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (day_carry && wday == 8'h06 && !wr_sel[3]) |=> (wday == 8'h00));

  a_r9_presc_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_sel[6:0]) |=> (presc_cnt == '0));

  a_r10_round_down: assert property (@(posedge clk) disable iff (!rst_n)
    (round_cmd && sec < 8'h30) |=> (sec == 8'h00 && $stable(min) && presc_cnt == '0));

  a_r11_round_up: assert property (@(posedge clk) disable iff (!rst_n)
    (round_cmd && sec >= 8'h30) |=> (sec == 8'h00 && min != $past(min)));

endmodule

bind rtc_calendar_core rtc_calendar_checker #(.PW(PW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sec_tick  (sec_tick),
  .round_cmd (round_cmd),
  .wr_sel    (wr_sel),
  .mode24    (mode24),
  .presc_cnt (presc_cnt),
  .min_step  (min_step),
  .day_carry (day_carry),
  .sec       (sec),
  .min       (min),
  .hour      (hour),
  .wday      (wday)
);

// File: tb/test_rtc_calendar_core.sv
`timescale 1ns/1ps
module test_rtc_calendar_core;

  localparam int unsigned DA = 4;
  localparam int unsigned DB = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0;
  logic       ref_sel = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rtc_calendar_core #(.DIV_A(DA), .DIV_B(DB)) i_rtc_calendar_core (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .ref_sel(ref_sel),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
  );

  function automatic logic [7:0] to_bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, rd_data, exp);
    end
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    ref_tick = 1'b1;
    repeat (n) @(negedge clk);
    ref_tick = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr(3'd2, h); wr(3'd1, m); wr(3'd0, s);
  endtask

  task automatic set_date(input logic [7:0] wd, input logic [7:0] d,
                          input logic [7:0] mo, input logic [7:0] y);
    wr(3'd3, wd); wr(3'd4, d); wr(3'd5, mo); wr(3'd6, y);
  endtask

  task automatic t_reset;
    chk(3'd0, 8'h00, "R1 sec");
    chk(3'd1, 8'h00, "R1 min");
    chk(3'd2, 8'h12, "R1 hour");
    chk(3'd3, 8'h00, "R1 wday");
    chk(3'd4, 8'h01, "R1 mday");
    chk(3'd5, 8'h01, "R1 month");
    chk(3'd6, 8'h00, "R1 year");
    chk(3'd7, 8'h02, "R1 ctrl");
  endtask

  task automatic t_divisors;
    wr(3'd7, 8'h01);
    chk(3'd7, 8'h01, "R12 ctrl after write");
    wr(3'd0, 8'h10);
    chk(3'd0, 8'h10, "R9 readback");
    ticks(DA - 1);
    chk(3'd0, 8'h10, "R2 div A early");
    ticks(1);
    chk(3'd0, 8'h11, "R2 div A full");
    ref_sel = 1'b1;
    wr(3'd0, 8'h10);
    ticks(DB - 1);
    chk(3'd0, 8'h10, "R2 div B early");
    ticks(1);
    chk(3'd0, 8'h11, "R2 div B full");
    ref_sel = 1'b0;
    // R9: a write mid-second restarts the count
    ticks(DA - 1);
    wr(3'd1, 8'h07);
    ticks(DA - 1);
    chk(3'd0, 8'h11, "R9 prescaler restarted");
    ticks(1);
    chk(3'd0, 8'h12, "R9 second after restart");
  endtask

  task automatic t_sweep;
    wr(3'd7, 8'h01);
    set_time(8'h05, 8'h00, 8'h00);
    for (int s = 1; s <= 61; s++) begin
      ticks(DA);
      chk(3'd0, to_bcd(s % 60), "R3 seconds sweep");
    end
    chk(3'd1, 8'h01, "R3 minute carry");
  endtask

  task automatic t_year_end_24h;
    wr(3'd7, 8'h01);
    set_date(8'h06, 8'h31, 8'h12, 8'h99);
    set_time(8'h23, 8'h59, 8'h59);
    ticks(DA);
    chk(3'd0, 8'h00, "R3 sec wrap");
    chk(3'd1, 8'h00, "R3 min wrap");
    chk(3'd2, 8'h00, "R4 hour 23 to 00");
    chk(3'd3, 8'h00, "R6 wday 6 to 0");
    chk(3'd4, 8'h01, "R7 mday wrap");
    chk(3'd5, 8'h01, "R7 month 12 to 01");
    chk(3'd6, 8'h00, "R7 year 99 to 00");
  endtask

  task automatic t_12h;
    wr(3'd7, 8'h00);
    set_date(8'h02, 8'h05, 8'h03, 8'h10);
    set_time(8'h11, 8'h59, 8'h59);
    ticks(DA);
    chk(3'd2, 8'h32, "R5 AM 11 to PM 12");
    chk(3'd4, 8'h05, "R5 no day at noon");
    set_time(8'h32, 8'h59, 8'h59);
    ticks(DA);
    chk(3'd2, 8'h21, "R5 PM 12 to PM 1");
    set_time(8'h09, 8'h59, 8'h59);
    ticks(DA);
    chk(3'd2, 8'h10, "R5 AM 9 to AM 10");
    set_time(8'h31, 8'h59, 8'h59);
    ticks(DA);
    chk(3'd2, 8'h12, "R5 PM 11 to AM 12");
    chk(3'd4, 8'h06, "R5 day advance at midnight");
    chk(3'd3, 8'h03, "R6 wday advances with day");
  endtask

  task automatic midnight(input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y);
    set_date(8'h01, d, mo, y);
    set_time(8'h23, 8'h59, 8'h59);
    ticks(DA);
  endtask

  task automatic t_months;
    wr(3'd7, 8'h01);
    midnight(8'h28, 8'h02, 8'h24);
    chk(3'd4, 8'h29, "R8 leap year 24 feb 29");
    midnight(8'h29, 8'h02, 8'h24);
    chk(3'd4, 8'h01, "R8 leap feb end");
    chk(3'd5, 8'h03, "R8 leap feb to mar");
    midnight(8'h28, 8'h02, 8'h23);
    chk(3'd4, 8'h01, "R8 common feb 28 end");
    chk(3'd5, 8'h03, "R8 common feb to mar");
    midnight(8'h28, 8'h02, 8'h00);
    chk(3'd4, 8'h29, "R8 year 00 leap");
    midnight(8'h28, 8'h02, 8'h10);
    chk(3'd4, 8'h01, "R8 year 10 not leap");
    midnight(8'h30, 8'h04, 8'h23);
    chk(3'd4, 8'h01, "R7 april 30 end");
    chk(3'd5, 8'h05, "R7 april to may");
    midnight(8'h30, 8'h01, 8'h23);
    chk(3'd4, 8'h31, "R7 january 31");
    midnight(8'h30, 8'h09, 8'h23);
    chk(3'd5, 8'h10, "R7 september to october");
  endtask

  task automatic t_round;
    wr(3'd7, 8'h01);
    set_date(8'h04, 8'h10, 8'h06, 8'h30);
    set_time(8'h08, 8'h10, 8'h29);
    ticks(2);
    wr(3'd7, 8'h03);
    chk(3'd0, 8'h00, "R10 round down sec");
    chk(3'd1, 8'h10, "R10 round down min unchanged");
    ticks(DA - 1);
    chk(3'd0, 8'h00, "R10 prescaler cleared");
    ticks(1);
    chk(3'd0, 8'h01, "R10 next full second");
    set_time(8'h08, 8'h10, 8'h30);
    wr(3'd7, 8'h03);
    chk(3'd0, 8'h00, "R11 round up sec");
    chk(3'd1, 8'h11, "R11 round up min");
    set_time(8'h23, 8'h59, 8'h45);
    wr(3'd7, 8'h03);
    chk(3'd1, 8'h00, "R11 round carry min");
    chk(3'd2, 8'h00, "R11 round carry hour");
    chk(3'd4, 8'h11, "R11 round carry day");
    chk(3'd7, 8'h01, "R12 round bit not read back");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_divisors();
    t_sweep();
    t_year_end_24h();
    t_12h();
    t_months();
    t_round();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule